// File: doc/BRIEF.md
# Security Byte Holder

This block keeps the device security byte. After every reset it issues exactly one read to nonvolatile memory for the phrase that holds the byte. It takes the byte from the correct lane of the returned phrase and latches it. The memory port is a plain request/response pair, and the response carries a double-bit-error flag. If that flag is set on the response, the block does not trust the data and latches all ones. All ones means secured, with backdoor access disabled.

From the latched byte the block decodes two things: whether backdoor-key access is allowed, and whether the device is secured. A separate key-comparison block sends a one-cycle unlock pulse when a backdoor key has matched. If the loaded byte allows backdoor access, the pulse forces the security field to the unsecured code and leaves every other bit unchanged. That forced value holds until the next reset, which reloads the byte from memory.

The byte is visible on a read-only bus view. Until the load finishes, every output reports the most restrictive state.

Top module: `secbyte_holder`

## Requirements
- R1: After reset release the block raises `mem_req` for exactly one cycle per reset. `mem_addr` is the phrase-aligned address 0x3FF08, and the security byte is taken from byte lane 7 (bits 63:56) of `mem_rdata`.
- R2: Until the load completes, `rd_data` reads 0xFF, `secured` is 1, `backdoor_en` is 0 and `load_done` is 0.
- R3: `load_done` rises on the clock edge after the edge that captures the response (`mem_rvalid` high). It then stays high until reset.
- R4: After the load, `rd_data` shows the captured byte: bits 7:6 are the key-enable field, bits 5:2 are reserved bits kept as loaded, and bits 1:0 are the security field.
- R5: A response with `mem_dbe` high loads 0xFF, whatever the data.
- R6: After the load, `backdoor_en` is 1 only when bits 7:6 equal 2'b10. The codes 00, 01 and 11 give 0.
- R7: After the load, `secured` is 0 only when bits 1:0 equal 2'b10. The codes 00, 01 and 11 give 1.
- R8: An `unlock` pulse seen while `backdoor_en` is 1 sets bits 1:0 to 2'b10 from the next cycle on. Bits 7:2 are unchanged, and `secured` drops to 0.
- R9: An `unlock` pulse while the load is pending, or while bits 7:6 are not 2'b10, leaves `rd_data` and `secured` unchanged.
- R10: A new reset discards any forced value and reloads the byte from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | ADDR_W | Phrase-aligned read address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 8*PHRASE_BYTES | Returned phrase |
| mem_dbe | input | 1 | Double-bit error on returned phrase |
| unlock | input | 1 | Backdoor key matched (one-cycle pulse) |
| rd_data | output | 8 | Read-only view of the security byte |
| load_done | output | 1 | Reset load finished |
| backdoor_en | output | 1 | Backdoor key access allowed |
| secured | output | 1 | Device is secured |

## Verification
Each wrong internal state shows up at the ports in a known cycle:
- A wrong lane select or a missed error flag shows in `rd_data` on the first cycle that `load_done` is high.
- A sequencer that skips or repeats a state shows as an extra `mem_req` or as `load_done` shifted by one cycle.
- An unlock that reaches the wrong bits, or that is taken when it should be ignored, changes `rd_data` and `secured` one cycle after the pulse.

The bench runs a behavioural model alongside the design and compares all outputs on every cycle, so any of these faults is reported in the cycle it first appears.

// File: rtl/secbyte_holder.sv
module secbyte_holder #(
  parameter int ADDR_W       = 18,
  parameter int PHRASE_BYTES = 8,
  parameter logic [ADDR_W-1:0] SEC_ADDR = 18'h3FF0F
) (
  input  logic                      clk,
  input  logic                      rst_n,
  output logic                      mem_req,
  output logic [ADDR_W-1:0]         mem_addr,
  input  logic                      mem_rvalid,
  input  logic [8*PHRASE_BYTES-1:0] mem_rdata,
  input  logic                      mem_dbe,
  input  logic                      unlock,
  output logic [7:0]                rd_data,
  output logic                      load_done,
  output logic                      backdoor_en,
  output logic                      secured
);
  localparam int LANE_W = $clog2(PHRASE_BYTES);

  typedef enum logic [1:0] {S_REQ, S_WAIT, S_CAP, S_DONE} st_t;

  st_t               st;
  logic [7:0]        byte_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        lane_byte;
  logic              key_open;

  assign lane_byte = mem_rdata[{addr_q[LANE_W-1:0], 3'b000} +: 8];
  assign key_open  = byte_q[7:6] == 2'b10;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_REQ;
      byte_q <= '1;
      addr_q <= SEC_ADDR;
    end else begin
      case (st)
        S_REQ:  st <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
                  byte_q <= mem_dbe ? 8'hFF : lane_byte;
                  st     <= S_CAP;
                end
        S_CAP:  st <= S_DONE;
        default: if (unlock && key_open) byte_q[1:0] <= 2'b10;
      endcase
    end
  end

  assign mem_req     = st == S_REQ;
  assign mem_addr    = {addr_q[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
  assign load_done   = st == S_DONE;
  assign rd_data     = load_done ? byte_q : 8'hFF;
  assign backdoor_en = load_done && key_open;
  assign secured     = !(load_done && byte_q[1:0] == 2'b10);
endmodule

// File: rtl/secbyte_holder_chk.sv
module secbyte_holder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_req,
  input logic       unlock,
  input logic [7:0] rd_data,
  input logic       load_done,
  input logic       backdoor_en,
  input logic       secured
);
  // R1
  req_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  // R2
  pending_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_done |-> (secured && !backdoor_en && rd_data == 8'hFF));
  // R3
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done);
  // R6
  key_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> (backdoor_en == (rd_data[7:6] == 2'b10)));
  // R7
  sec_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> (secured == (rd_data[1:0] != 2'b10)));
  // R8
  unlock_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (backdoor_en && unlock) |=> (rd_data[1:0] == 2'b10 && !secured));
  // R8
  upper_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> $stable(rd_data[7:2]));
  // R9
  locked_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && !backdoor_en) |=> $stable(rd_data));
endmodule

bind secbyte_holder secbyte_holder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .unlock(unlock),
  .rd_data(rd_data), .load_done(load_done), .backdoor_en(backdoor_en),
  .secured(secured)
);

// File: tb/secbyte_holder_bench.sv
module secbyte_holder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req;
  logic [17:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        mem_dbe = 1'b0;
  logic        unlock = 1'b0;
  logic [7:0]  rd_data;
  logic        load_done, backdoor_en, secured;

  int checks = 0, fails = 0, req_seen = 0;
  bit finished = 0;

  // reference model state
  bit       m_done = 0, m_cap = 0;
  bit [7:0] m_byte = 8'hFF;

  always #10 clk = ~clk;

  secbyte_holder u_secbyte_holder (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_dbe(mem_dbe),
    .unlock(unlock), .rd_data(rd_data), .load_done(load_done),
    .backdoor_en(backdoor_en), .secured(secured)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_done = 0; m_cap = 0; m_byte = 8'hFF;
    end else if (!m_cap && mem_rvalid) begin
      m_cap = 1;
      m_byte = mem_dbe ? 8'hFF : mem_rdata[63:56];
    end else if (m_cap && !m_done) begin
      m_done = 1;
    end else if (m_done && unlock && m_byte[7:6] == 2'b10) begin
      m_byte[1:0] = 2'b10;
    end
  end

  always @(negedge clk) if (rst_n) begin
    check("R3 load_done", load_done, m_done);
    check(m_done ? "R4 rd_data" : "R2 rd_data", rd_data, m_done ? m_byte : 8'hFF);
    check("R6 backdoor_en", backdoor_en, m_done && m_byte[7:6] == 2'b10);
    check("R7 secured", secured, !(m_done && m_byte[1:0] == 2'b10));
    if (mem_req) begin
      req_seen++;
      check("R1 mem_addr", mem_addr, 18'h3FF08);
    end
  end

  task automatic run_case(logic [7:0] b, bit dbe, bit early_unlock, bit late_unlock, int lat);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    req_seen = 0;
    @(negedge clk);
    check("R2 pending load_done", load_done, 0);
    if (early_unlock) begin unlock = 1'b1; @(negedge clk); unlock = 1'b0; end // R9 pending
    repeat (lat) @(negedge clk);
    mem_rdata = {b, 56'h5A5A_1234_C3C3_77};
    mem_dbe = dbe;
    mem_rvalid = 1'b1;
    @(negedge clk);
    mem_rvalid = 1'b0; mem_dbe = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    if (late_unlock) begin unlock = 1'b1; @(negedge clk); unlock = 1'b0; end // R8 / R9
    repeat (3) @(negedge clk);
    check("R1 single request", req_seen, 1);
  endtask

  initial begin
    run_case(8'hBC, 0, 1, 1, 2);  // R8: key 10, secured 00 -> forced 0xBE
    check("R8 forced byte", rd_data, 8'hBE);
    run_case(8'h3E, 0, 0, 1, 1);  // R9: key 00, unlock ignored, unsecured
    check("R9 ignored", rd_data, 8'h3E);
    run_case(8'h82, 1, 0, 1, 3);  // R5: double-bit error
    check("R5 dbe byte", rd_data, 8'hFF);
    run_case(8'hC5, 0, 0, 1, 0);  // R6 key 11 disabled, R7 sec 01 secured
    check("R7 secured 01", secured, 1);
    run_case(8'h4B, 0, 0, 1, 1);  // key 01, sec 11
    check("R6 key 01", backdoor_en, 0);
    run_case(8'hBF, 0, 0, 1, 2);  // unlock forces 11 -> 10
    check("R8 forced 0xBE", rd_data, 8'hBE);
    run_case(8'hBF, 0, 0, 0, 2);  // R10: reload discards forced value
    check("R10 reload", rd_data, 8'hBF);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule